// File: doc/BRIEF.md
# Receive Character Queue with Threshold Flow Control

This block buffers received characters for one serial channel. Each entry is a data byte paired with a three-bit error status. Data and status sit in aligned storage and leave the queue together. The character receiver pushes entries through the write port. The host pops the oldest entry with a single read strobe and sees that entry on the read outputs before it pops it.

A programmable threshold sets the fill level at which two things happen. The host is asked for service, and the flow-control output toward the remote end (the DTR line) is dropped so that the remote stops sending. The block also reports how many entries at the head of the queue carry no error flags. With that count the host can drain that many bytes without inspecting status. A write that finds the queue full is discarded and marks an overrun on the newest stored entry.

Top module: `rx_thresh_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 8) entries in arrival order, and `fill_lvl` gives the current occupancy. While the queue is not empty, `rd_data`/`rd_stat` show the oldest entry, and a `rd_en` pulse removes that data byte and its status together.
- R2: Each entry stores the 3-bit status given with its byte: bit 0 is parity error, bit 1 is framing error and bit 2 is overrun. The status is returned unchanged on `rd_stat` unless R3 applies.
- R3: A write while the queue is full, with no read in the same cycle, is dropped. `fill_lvl` stays at DEPTH and bit 2 of the newest stored entry's status is set.
- R4: A write and a read in the same cycle on a full queue both take effect. The oldest entry leaves, the new entry is appended and `fill_lvl` stays at DEPTH.
- R5: A read strobe on an empty queue has no effect. `fill_lvl` stays 0, and a later write is the entry read first.
- R6: The effective threshold is `rx_thr` clamped to the range 1..DEPTH: 0 acts as 1, and values above DEPTH act as DEPTH.
- R7: `rx_svc_req` is high exactly when `fill_lvl` is at or above the effective threshold.
- R8: `flow_ok` (DTR asserted) is low while `fill_lvl` is at or above the effective threshold and high once it is below.
- R9: `clean_cnt` equals the number of consecutive entries, starting at the head, whose status is all zero. It stops at the first entry with any status bit set.
- R10: After reset the queue is empty: `fill_lvl` and `clean_cnt` are 0, `rx_svc_req` is 0 and `flow_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push a received character |
| wr_data | input | 8 | Received data byte |
| wr_stat | input | 3 | Status of the byte: bit0 parity, bit1 framing, bit2 overrun |
| rd_en | input | 1 | Pop the head entry (data and status) |
| rd_data | output | 8 | Data byte at the head |
| rd_stat | output | 3 | Status at the head |
| rx_thr | input | 4 | Programmed threshold, clamped to 1..DEPTH |
| fill_lvl | output | 4 | Number of stored entries |
| clean_cnt | output | 4 | Error-free entries at the head |
| rx_svc_req | output | 1 | Receive service request |
| flow_ok | output | 1 | DTR level: high while the remote may send |

## Verification
Push and pop can land in the same cycle. On a full queue this decides whether a write is accepted or dropped with an overrun mark. The bench drives a write and a read strobe together on a full queue, and also drives a lone write on a full queue. A reference queue follows the acceptance rule, and its popped items are compared with `rd_data`/`rd_stat`. The bench also checks that `fill_lvl` stays at DEPTH in both cases and that only the lone write marks the tail.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int STAT_W  = 3;
   localparam int PAR_BIT = 0;
   localparam int FRM_BIT = 1;
   localparam int OVR_BIT = 2;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int SW    = rxq_pkg::STAT_W,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic                       mark_ovr,
   input  logic [DW-1:0]              wdata,
   input  logic [SW-1:0]              wstat,
   output logic [DW-1:0]              rdata,
   output logic [SW-1:0]              rstat,
   output logic [PW-1:0]              head,
   output logic [LW-1:0]              level,
   output logic [DEPTH-1:0][SW-1:0]   stat_all
);
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [DEPTH-1:0][SW-1:0] stat_q;
   logic [PW-1:0]            head_q, tail_q, newest;
   logic [LW-1:0]            cnt_q;

   assign newest = tail_q - PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         stat_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (push && tail_q == PW'(e)) begin
               data_q[e] <= wdata;
               stat_q[e] <= wstat;
            end else if (mark_ovr && newest == PW'(e)) begin
               stat_q[e][rxq_pkg::OVR_BIT] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= tail_q + PW'(1);
         if (pop)  head_q <= head_q + PW'(1);
         cnt_q <= cnt_q + LW'(push) - LW'(pop);
      end
   end

   assign rdata    = data_q[head_q];
   assign rstat    = stat_q[head_q];
   assign head     = head_q;
   assign level    = cnt_q;
   assign stat_all = stat_q;

   // R3
   ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mark_ovr |=> stat_q[$past(newest)][rxq_pkg::OVR_BIT]);
endmodule

// File: rtl/rxq_goodcnt.sv
module rxq_goodcnt #(
   parameter int DEPTH = 8,
   parameter int SW    = rxq_pkg::STAT_W,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0][SW-1:0] stat_all,
   input  logic [PW-1:0]            head,
   input  logic [LW-1:0]            level,
   output logic [LW-1:0]            good
);
   logic [DEPTH-1:0] blocked;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] idx;
      assign idx        = head + PW'(i);
      assign blocked[i] = (LW'(i) >= level) || (|stat_all[idx]);
   end

   always_comb begin
      good = LW'(DEPTH);
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (blocked[i]) good = LW'(i);
      end
   end
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
   parameter int DEPTH = 8,
   parameter int TW    = 4,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic [TW-1:0] thr_in,
   input  logic [LW-1:0] level,
   output logic [LW-1:0] thr_eff,
   output logic          req,
   output logic          flow
);
   always_comb begin
      if (thr_in == '0)
         thr_eff = LW'(1);
      else if (int'(thr_in) > DEPTH)
         thr_eff = LW'(DEPTH);
      else
         thr_eff = LW'(thr_in);
   end

   assign req  = (level >= thr_eff);
   assign flow = ~req;
endmodule

// File: rtl/rx_thresh_fifo.sv
module rx_thresh_fifo #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int TW    = 4,
   localparam int SW   = rxq_pkg::STAT_W,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic [SW-1:0] wr_stat,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [SW-1:0] rd_stat,
   input  logic [TW-1:0] rx_thr,
   output logic [LW-1:0] fill_lvl,
   output logic [LW-1:0] clean_cnt,
   output logic          rx_svc_req,
   output logic          flow_ok
);
   initial begin : prm_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (TW >= LW) else $error("TW too narrow for DEPTH");
   end

   logic                     push, pop, mark_ovr, full, empty;
   logic [PW-1:0]            head;
   logic [DEPTH-1:0][SW-1:0] stat_all;
   logic [LW-1:0]            thr_eff;

   assign full     = (fill_lvl == LW'(DEPTH));
   assign empty    = (fill_lvl == '0);
   assign pop      = rd_en && !empty;
   assign push     = wr_en && (!full || rd_en);
   assign mark_ovr = wr_en && full && !rd_en;

   rxq_store #(.DEPTH(DEPTH), .DW(DW), .SW(SW)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .mark_ovr(mark_ovr),
      .wdata(wr_data), .wstat(wr_stat), .rdata(rd_data), .rstat(rd_stat),
      .head(head), .level(fill_lvl), .stat_all(stat_all));

   rxq_goodcnt #(.DEPTH(DEPTH), .SW(SW)) u_good (
      .stat_all(stat_all), .head(head), .level(fill_lvl), .good(clean_cnt));

   rxq_thresh #(.DEPTH(DEPTH), .TW(TW)) u_thr (
      .thr_in(rx_thr), .level(fill_lvl), .thr_eff(thr_eff),
      .req(rx_svc_req), .flow(flow_ok));

   // R1
   lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= LW'(DEPTH));
   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> full);
   // R4
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && full) |=> full);
   // R5
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && empty) |=> empty);
   // R1
   lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && !full) |=> fill_lvl == $past(fill_lvl) + LW'(1));
   // R9
   good_le_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clean_cnt <= fill_lvl);
   // R9
   good_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && clean_cnt != '0) |=> clean_cnt == $past(clean_cnt) - LW'(1));
   // R6
   thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_eff >= LW'(1) && thr_eff <= LW'(DEPTH));
   // R8
   flow_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_svc_req != flow_ok);
endmodule

// File: tb/rx_thresh_fifo_bench.sv
`timescale 1ns/1ps
module rx_thresh_fifo_bench;
   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] wr_stat = '0;
   logic [3:0] rx_thr = 4'd4;
   logic [7:0] rd_data;
   logic [2:0] rd_stat;
   logic [3:0] fill_lvl, clean_cnt;
   logic       rx_svc_req, flow_ok;

   int nchk = 0, nerr = 0;
   bit mon_on = 1'b0, done = 1'b0;
   logic [10:0] q[$];

   always #2.5 clk = ~clk;

   rx_thresh_fifo u_rx_thresh_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_stat(wr_stat), .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat),
      .rx_thr(rx_thr), .fill_lvl(fill_lvl), .clean_cnt(clean_cnt),
      .rx_svc_req(rx_svc_req), .flow_ok(flow_ok));

   task automatic chk(input int act, input int exp, input string tag);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int thr_of(input logic [3:0] t);
      if (t == 0) return 1;
      if (t > DEPTH) return DEPTH;
      return int'(t);
   endfunction

   function automatic int good_of();
      int g = 0;
      foreach (q[i]) begin
         if (q[i][10:8] != 3'b000) break;
         g++;
      end
      return g;
   endfunction

   // driver: one cycle of stimulus
   task automatic drv(input bit w, input logic [7:0] d, input logic [2:0] s, input bit r);
      @(posedge clk); #1;
      wr_en = w; wr_data = d; wr_stat = s; rd_en = r;
   endtask

   task automatic idle_settle();
      drv(0, 8'h00, 3'b000, 0);
      @(negedge clk);
   endtask

   // monitor and scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         chk(fill_lvl, q.size(), "R1 level");
         chk(clean_cnt, good_of(), "R9 clean count");
         chk(rx_svc_req, (q.size() >= thr_of(rx_thr)), "R7 service request");
         chk(flow_ok, (q.size() < thr_of(rx_thr)), "R8 flow level");
         if (rd_en && q.size() > 0) begin
            logic [10:0] e;
            e = q.pop_front();
            chk(rd_data, e[7:0], "R1 read data");
            chk(rd_stat, e[10:8], "R2 read status");
         end
         if (wr_en) begin
            if (q.size() < DEPTH) q.push_back({wr_stat, wr_data});
            else q[q.size()-1][10] = 1'b1;
         end
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      #500000;
      nerr++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(fill_lvl, 0, "R10 level");
      chk(clean_cnt, 0, "R10 clean count");
      chk(rx_svc_req, 0, "R10 request");
      chk(flow_ok, 1, "R10 flow");
      mon_on = 1'b1;

      // fill past threshold 4, then overflow
      rx_thr = 4'd4;
      for (int i = 0; i < DEPTH; i++) drv(1, 8'h10 + 8'(i), 3'b000, 0);
      drv(1, 8'hEE, 3'b000, 0);
      idle_settle();
      chk(fill_lvl, DEPTH, "R3 level after dropped write");
      // simultaneous read and write on full
      drv(1, 8'hA5, 3'b010, 1);
      idle_settle();
      chk(fill_lvl, DEPTH, "R4 level after swap");
      for (int i = 0; i < DEPTH; i++) drv(0, 8'h00, 3'b000, 1);
      // reads on empty
      drv(0, 8'h00, 3'b000, 1);
      drv(0, 8'h00, 3'b000, 1);
      idle_settle();
      chk(fill_lvl, 0, "R5 level after empty reads");
      drv(1, 8'h77, 3'b000, 1);
      idle_settle();
      chk(rd_data, 8'h77, "R5 head after empty reads");
      drv(0, 8'h00, 3'b000, 1);

      // mixed status entries
      rx_thr = 4'd3;
      drv(1, 8'h21, 3'b000, 0);
      drv(1, 8'h22, 3'b000, 0);
      drv(1, 8'h23, 3'b001, 0);
      drv(1, 8'h24, 3'b000, 0);
      drv(1, 8'h25, 3'b010, 0);
      idle_settle();
      chk(clean_cnt, 2, "R9 stops at parity entry");
      drv(0, 8'h00, 3'b000, 1);
      drv(0, 8'h00, 3'b000, 1);
      idle_settle();
      chk(clean_cnt, 0, "R9 head has error");
      drv(0, 8'h00, 3'b000, 1);
      idle_settle();
      chk(clean_cnt, 1, "R9 one clean before framing");
      drv(0, 8'h00, 3'b000, 1);
      drv(0, 8'h00, 3'b000, 1);

      // clamping
      rx_thr = 4'd0;
      drv(1, 8'h31, 3'b000, 0);
      idle_settle();
      chk(rx_svc_req, 1, "R6 zero acts as one");
      drv(0, 8'h00, 3'b000, 1);
      rx_thr = 4'd13;
      for (int i = 0; i < DEPTH - 1; i++) drv(1, 8'h40 + 8'(i), 3'b100, 0);
      idle_settle();
      chk(rx_svc_req, 0, "R6 high value below depth");
      chk(flow_ok, 1, "R8 below clamped threshold");
      drv(1, 8'h4F, 3'b000, 0);
      idle_settle();
      chk(rx_svc_req, 1, "R6 high value acts as depth");
      for (int i = 0; i < DEPTH; i++) drv(0, 8'h00, 3'b000, 1);
      idle_settle();
      chk(flow_ok, 1, "R8 flow back after drain");

      repeat (2) @(negedge clk);
      summary();
   end
endmodule